// File: doc/BRIEF.md
# Receive descriptor ring index manager

This block keeps the bookkeeping for a circular ring of receive buffer descriptors shared by a device and a host. The device reports how far it has filled the ring through a closed-buffer count, which sets the read position. The host restocks slots by presenting buffer addresses. Each accepted address is stored in the ring as a compressed descriptor pointer (the address with its low 8 bits dropped), and the write index moves forward by one.

From the two indices the block derives the free space, which always holds back two slots, and the empty and full conditions. It publishes a coarse copy of the write index to the device that moves only in steps of eight slots. It flags urgent refill mode when too many slots are waiting behind the published pointer, and in that mode asks for a restock every eighth processed entry. A registered low-watermark flag compares the host's count of spare buffers with a threshold. Restocks with a malformed address, or restocks that arrive with no free space, are refused. A malformed address raises a one-cycle error, and a restock refused for lack of space raises a stall flag that stays up until space returns.

Top module: `rx_ring_idx_mgr`

## Requirements
- R1: After reset the read index is 0, the write index is DEPTH-1 (255), the ring reports empty and not full, free space is 0, the published pointer is DEPTH-8 (248), and the publish strobe, error, stall and refill outputs are 0.
- R2: On a cycle with `dev_pos_vld` high, the read index takes the low log2(DEPTH) bits of `dev_pos` at the next edge. Bits 12 and above of the count are ignored.
- R3: Free space is (read - write) mod DEPTH, with 0 replaced by DEPTH, minus 2 and clamped at 0. It never exceeds DEPTH-2.
- R4: `ring_full` is high exactly when write equals read. `ring_empty` is high exactly when write equals read minus one, modulo DEPTH.
- R5: A restock is accepted (`fill_ack` high in the same cycle) when the address is well formed and free space is nonzero. At the next edge, address bits [35:8] are stored in the slot at the write index, and the write index advances by one, wrapping from DEPTH-1 to 0.
- R6: An address with any of bits [7:0] set, or any bit at position 36 or above set, is refused. Nothing is stored, the write index does not move, and `fill_err` is high for the one cycle after the request.
- R7: A well-formed restock that meets zero free space is refused. `fill_stall` rises at the next edge, stays high while free space is zero, and clears at the first edge at which free space is nonzero.
- R8: The published pointer equals the write index with its low 3 bits cleared. It is updated, with `pub_strobe` high for one cycle, one edge after that rounded value changes, and it holds otherwise.
- R9: `urgent` is high when (read - published pointer) mod DEPTH is greater than DEPTH/2. It is low at exactly DEPTH/2.
- R10: While urgent, `refill_req` pulses for one cycle after every eighth `consume` pulse. The tally of consume pulses restarts from zero whenever urgent is low.
- R11: `low_wm` is registered and is high when `pool_cnt` is less than or equal to `low_thresh`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_pos_vld | input | 1 | Device closed-buffer count valid |
| dev_pos | input | CLOSED_W (16) | Device closed-buffer count |
| fill_vld | input | 1 | Restock request |
| fill_addr | input | HOST_AW (40) | Buffer address of the restock |
| fill_ack | output | 1 | Restock accepted this cycle |
| fill_err | output | 1 | Previous request had a malformed address |
| fill_stall | output | 1 | A restock was refused for lack of space |
| look_slot | input | log2(DEPTH) | Slot to read back |
| look_desc | output | DMA_AW-ALIGN_SH (28) | Descriptor pointer stored in `look_slot` |
| ring_rd | output | log2(DEPTH) | Read index |
| ring_wr | output | log2(DEPTH) | Write index |
| free_slots | output | log2(DEPTH)+1 | Free space |
| ring_empty | output | 1 | Empty condition |
| ring_full | output | 1 | Full condition |
| pub_wptr | output | log2(DEPTH) | Write pointer published to the device |
| pub_strobe | output | 1 | Published pointer changed this cycle |
| consume | input | 1 | Host processed one entry |
| urgent | output | 1 | Urgent refill mode |
| refill_req | output | 1 | Restock request in urgent mode |
| pool_cnt | input | POOL_W (16) | Host count of spare buffers |
| low_thresh | input | POOL_W (16) | Low-watermark threshold |
| low_wm | output | 1 | Spare buffers at or below threshold |

## Verification
Two situations are hard to reach from the ports. The first is the stall: free space holds back two slots, so the ring has to be restocked until only the reserve is left. The second is urgent mode: the read position has to run more than half a ring ahead of the published pointer. The stimulus gets to both by writing the device count directly. It first opens a small window and fills it completely with restocks, then makes one more restock that must stall. Later it jumps the read position to values on either side of the half-ring boundary. The eight-entry refill cadence is then checked twice: once from a fresh entry into urgent mode, and once after a short excursion out of urgent mode, to show that the tally restarts.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   // device closed-buffer counts carry a 12-bit position
   localparam int RXR_POS_BITS = 12;
   // smallest ring that still leaves room after the reserve
   localparam int RXR_MIN_DEPTH = 4;
endpackage

// File: rtl/rxr_space_calc.sv
module rxr_space_calc #(
   parameter int DEPTH = 256,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic [IDX_W-1:0] rd,
   input  logic [IDX_W-1:0] wr,
   output logic [CNT_W-1:0] free_slots,
   output logic             empty,
   output logic             full
);
   logic [IDX_W-1:0] gap;
   logic [IDX_W-1:0] rd_prev;
   logic [CNT_W-1:0] span;

   always_comb begin
      gap     = rd - wr;
      rd_prev = rd - 1'b1;
      // a zero gap counts as a whole ring
      span    = (gap == '0) ? CNT_W'(DEPTH) : {1'b0, gap};
      free_slots = (span >= CNT_W'(2)) ? span - CNT_W'(2) : '0;
      full    = (wr == rd);
      empty   = (wr == rd_prev);
   end
endmodule

// File: rtl/rxr_desc_store.sv
module rxr_desc_store #(
   parameter int DEPTH  = 256,
   parameter int DESC_W = 28,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  wslot,
   input  logic [DESC_W-1:0] wdata,
   input  logic [IDX_W-1:0]  look_slot,
   output logic [DESC_W-1:0] look_desc
);
   logic [DESC_W-1:0] slots [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) slots[k] <= '0;
      end else if (we) begin
         slots[wslot] <= wdata;
      end
   end

   assign look_desc = slots[look_slot];
endmodule

// File: rtl/rxr_publish.sv
module rxr_publish #(
   parameter int DEPTH  = 256,
   parameter int PUB_SH = 3,
   parameter int BURST  = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int TW    = (BURST > 2) ? $clog2(BURST) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] wr,
   input  logic [IDX_W-1:0] rd,
   input  logic             consume,
   output logic [IDX_W-1:0] pub_wptr,
   output logic             pub_strobe,
   output logic             urgent,
   output logic             refill_req
);
   localparam logic [IDX_W-1:0] HALF     = IDX_W'(DEPTH / 2);
   localparam logic [TW-1:0]    LAST     = TW'(BURST - 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

   logic [IDX_W-1:0] rnd_wr;
   logic [IDX_W-1:0] rnd_rst;
   logic [IDX_W-1:0] pending;
   logic [TW-1:0]    tally;

   generate
      if (PUB_SH == 0) begin : g_fine
         assign rnd_wr  = wr;
         assign rnd_rst = LAST_IDX;
      end else begin : g_coarse
         assign rnd_wr  = {wr[IDX_W-1:PUB_SH], {PUB_SH{1'b0}}};
         assign rnd_rst = {LAST_IDX[IDX_W-1:PUB_SH], {PUB_SH{1'b0}}};
      end
   endgenerate

   assign pending = rd - pub_wptr;
   assign urgent  = (pending > HALF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pub_wptr   <= rnd_rst;
         pub_strobe <= 1'b0;
      end else begin
         pub_strobe <= (rnd_wr != pub_wptr);
         if (rnd_wr != pub_wptr) pub_wptr <= rnd_wr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tally      <= '0;
         refill_req <= 1'b0;
      end else begin
         refill_req <= urgent && consume && (tally == LAST);
         if (!urgent)      tally <= '0;
         else if (consume) tally <= (tally == LAST) ? '0 : tally + 1'b1;
      end
   end
endmodule

// File: rtl/rx_ring_idx_mgr.sv
module rx_ring_idx_mgr
   import rxr_pkg::*;
#(
   parameter int DEPTH    = 256,
   parameter int HOST_AW  = 40,
   parameter int DMA_AW   = 36,
   parameter int ALIGN_SH = 8,
   parameter int PUB_SH   = 3,
   parameter int BURST    = 8,
   parameter int CLOSED_W = 16,
   parameter int POOL_W   = 16,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int CNT_W   = IDX_W + 1,
   localparam int DESC_W  = DMA_AW - ALIGN_SH
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                dev_pos_vld,
   input  logic [CLOSED_W-1:0] dev_pos,
   input  logic                fill_vld,
   input  logic [HOST_AW-1:0]  fill_addr,
   output logic                fill_ack,
   output logic                fill_err,
   output logic                fill_stall,
   input  logic [IDX_W-1:0]    look_slot,
   output logic [DESC_W-1:0]   look_desc,
   output logic [IDX_W-1:0]    ring_rd,
   output logic [IDX_W-1:0]    ring_wr,
   output logic [CNT_W-1:0]    free_slots,
   output logic                ring_empty,
   output logic                ring_full,
   output logic [IDX_W-1:0]    pub_wptr,
   output logic                pub_strobe,
   input  logic                consume,
   output logic                urgent,
   output logic                refill_req,
   input  logic [POOL_W-1:0]   pool_cnt,
   input  logic [POOL_W-1:0]   low_thresh,
   output logic                low_wm
);
   // elaboration-time parameter checks
   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < RXR_MIN_DEPTH) begin : g_bad_depth
         $error("ring depth must be a power of two of at least %0d", RXR_MIN_DEPTH);
      end
      if (IDX_W > RXR_POS_BITS || CLOSED_W <= IDX_W) begin : g_bad_pos
         $error("ring index must fit the 12-bit closed count");
      end
      if (HOST_AW < DMA_AW || ALIGN_SH < 1 || ALIGN_SH >= DMA_AW) begin : g_bad_addr
         $error("address widths are inconsistent");
      end
      if (PUB_SH >= IDX_W || BURST < 2) begin : g_bad_grain
         $error("publish step or refill cadence out of range");
      end
   endgenerate

   logic hi_ok;
   logic lo_ok;
   logic addr_ok;
   logic space_ok;
   logic unused_pos;

   generate
      if (HOST_AW > DMA_AW) begin : g_hi_chk
         assign hi_ok = ~|fill_addr[HOST_AW-1:DMA_AW];
      end else begin : g_hi_none
         assign hi_ok = 1'b1;
      end
   endgenerate

   assign lo_ok      = ~|fill_addr[ALIGN_SH-1:0];
   assign addr_ok    = hi_ok && lo_ok;
   assign space_ok   = (free_slots != '0);
   assign fill_ack   = fill_vld && addr_ok && space_ok;
   assign unused_pos = ^dev_pos[CLOSED_W-1:IDX_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ring_rd    <= '0;
         ring_wr    <= IDX_W'(DEPTH - 1);
         fill_err   <= 1'b0;
         fill_stall <= 1'b0;
         low_wm     <= 1'b0;
      end else begin
         if (dev_pos_vld) ring_rd <= dev_pos[IDX_W-1:0];
         if (fill_ack)    ring_wr <= ring_wr + 1'b1;
         fill_err <= fill_vld && !addr_ok;
         if (space_ok) fill_stall <= 1'b0;
         else          fill_stall <= fill_stall || (fill_vld && addr_ok);
         low_wm <= (pool_cnt <= low_thresh);
      end
   end

   rxr_space_calc #(.DEPTH(DEPTH)) i_space (
      .rd         (ring_rd),
      .wr         (ring_wr),
      .free_slots (free_slots),
      .empty      (ring_empty),
      .full       (ring_full)
   );

   rxr_desc_store #(.DEPTH(DEPTH), .DESC_W(DESC_W)) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (fill_ack),
      .wslot     (ring_wr),
      .wdata     (fill_addr[DMA_AW-1:ALIGN_SH]),
      .look_slot (look_slot),
      .look_desc (look_desc)
   );

   rxr_publish #(.DEPTH(DEPTH), .PUB_SH(PUB_SH), .BURST(BURST)) i_pub (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (ring_wr),
      .rd         (ring_rd),
      .consume    (consume),
      .pub_wptr   (pub_wptr),
      .pub_strobe (pub_strobe),
      .urgent     (urgent),
      .refill_req (refill_req)
   );
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
   parameter int DEPTH = 256,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fill_vld,
   input logic             fill_ack,
   input logic             fill_err,
   input logic             fill_stall,
   input logic [IDX_W-1:0] ring_wr,
   input logic [CNT_W-1:0] free_slots,
   input logic [IDX_W-1:0] pub_wptr,
   input logic             pub_strobe,
   input logic             urgent,
   input logic             refill_req
);
   assert_free_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      free_slots <= CNT_W'(DEPTH - 2));

   assert_ack_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fill_ack |=> ring_wr == IDX_W'($past(ring_wr) + 1'b1));

   assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_ack |=> $stable(ring_wr));

   assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fill_err |-> ($past(fill_vld) && !$past(fill_ack)));

   assert_stall_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_stall && free_slots != '0) |=> !fill_stall);

   assert_pub_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pub_strobe |-> $stable(pub_wptr));

   assert_pub_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pub_strobe |-> (pub_wptr != $past(pub_wptr)));

   assert_refill_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      refill_req |-> $past(urgent));
endmodule

bind rx_ring_idx_mgr rxr_checker #(.DEPTH(DEPTH)) i_rxr_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .fill_vld   (fill_vld),
   .fill_ack   (fill_ack),
   .fill_err   (fill_err),
   .fill_stall (fill_stall),
   .ring_wr    (ring_wr),
   .free_slots (free_slots),
   .pub_wptr   (pub_wptr),
   .pub_strobe (pub_strobe),
   .urgent     (urgent),
   .refill_req (refill_req)
);

// File: tb/test_rx_ring_idx_mgr.sv
module test_rx_ring_idx_mgr;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 256;
   localparam int IDX_W = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        dev_pos_vld;
   logic [15:0] dev_pos;
   logic        fill_vld;
   logic [39:0] fill_addr;
   logic        fill_ack;
   logic        fill_err;
   logic        fill_stall;
   logic [7:0]  look_slot;
   logic [27:0] look_desc;
   logic [7:0]  ring_rd;
   logic [7:0]  ring_wr;
   logic [8:0]  free_slots;
   logic        ring_empty;
   logic        ring_full;
   logic [7:0]  pub_wptr;
   logic        pub_strobe;
   logic        consume;
   logic        urgent;
   logic        refill_req;
   logic [15:0] pool_cnt;
   logic [15:0] low_thresh;
   logic        low_wm;

   int checks = 0;
   int fails  = 0;
   int pubs_seen = 0;
   bit done = 0;

   // scoreboard queues
   logic [7:0]  exp_pub_q [$];
   logic [7:0]  exp_slot_q [$];
   logic [27:0] exp_desc_q [$];
   logic [7:0]  m_wr;
   logic [7:0]  m_pub;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rx_ring_idx_mgr i_rx_ring_idx_mgr (
      .clk(clk), .rst_n(rst_n),
      .dev_pos_vld(dev_pos_vld), .dev_pos(dev_pos),
      .fill_vld(fill_vld), .fill_addr(fill_addr),
      .fill_ack(fill_ack), .fill_err(fill_err), .fill_stall(fill_stall),
      .look_slot(look_slot), .look_desc(look_desc),
      .ring_rd(ring_rd), .ring_wr(ring_wr), .free_slots(free_slots),
      .ring_empty(ring_empty), .ring_full(ring_full),
      .pub_wptr(pub_wptr), .pub_strobe(pub_strobe),
      .consume(consume), .urgent(urgent), .refill_req(refill_req),
      .pool_cnt(pool_cnt), .low_thresh(low_thresh), .low_wm(low_wm)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic set_pos(input logic [15:0] p);
      dev_pos = p;
      dev_pos_vld = 1'b1;
      step();
      dev_pos_vld = 1'b0;
      #1;
   endtask

   // driver: presents a restock and pushes what the design must produce
   task automatic do_fill(input logic [39:0] a, input logic exp_ack, input string req);
      fill_addr = a;
      fill_vld = 1'b1;
      #1;
      chk(req, fill_ack, exp_ack);
      if (exp_ack) begin
         exp_slot_q.push_back(m_wr);
         exp_desc_q.push_back(a[35:8]);
         m_wr = m_wr + 8'd1;
         if ((m_wr & 8'hF8) != m_pub) begin
            m_pub = m_wr & 8'hF8;
            exp_pub_q.push_back(m_pub);
         end
      end
      step();
      fill_vld = 1'b0;
      #1;
   endtask

   // monitor: every publish strobe must match the next expected pointer (R8)
   always @(negedge clk) begin
      if (rst_n === 1'b1 && pub_strobe === 1'b1) begin
         pubs_seen++;
         if (exp_pub_q.size() == 0) chk("R8 unexpected publish", pub_wptr, 8'hxx);
         else chk("R8 published pointer", pub_wptr, exp_pub_q.pop_front());
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; dev_pos_vld = 0; dev_pos = '0; fill_vld = 0; fill_addr = '0;
      look_slot = '0; consume = 0; pool_cnt = 16'd100; low_thresh = 16'd5;
      m_wr = 8'd255; m_pub = 8'd248;
      repeat (3) step();
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 read index", ring_rd, 0);
      chk("R1 write index", ring_wr, 255);
      chk("R1 empty", ring_empty, 1);
      chk("R1 full", ring_full, 0);
      chk("R1 free space", free_slots, 0);
      chk("R1 published", pub_wptr, 248);
      chk("R1 strobe/err/stall/refill", {pub_strobe, fill_err, fill_stall, refill_req}, 0);

      // R2 high bits of the closed count are ignored
      set_pos(16'hF00A);
      chk("R2 read from masked count", ring_rd, 10);
      chk("R3 free space after open", free_slots, 9);
      chk("R4 neither empty nor full", {ring_empty, ring_full}, 0);

      // R5 fill the open window, wrapping the write index
      for (int i = 0; i < 8; i++)
         do_fill(40'h0A_0000_0000 | (40'(i + 1) << 8), 1'b1, "R5 accept");
      do_fill(40'h0F_FFFF_FF00, 1'b1, "R5 accept top address");
      chk("R5 write index wrapped", ring_wr, 8);
      chk("R3 free space exhausted", free_slots, 0);

      // R7 stall on zero space
      do_fill(40'h0A_0000_1000, 1'b0, "R7 refuse on full");
      chk("R7 stall raised", fill_stall, 1);
      chk("R7 write index unchanged", ring_wr, 8);
      step();
      chk("R7 stall held", fill_stall, 1);
      set_pos(16'd20);
      chk("R3 free space reopened", free_slots, 10);
      chk("R7 stall still up at first edge", fill_stall, 1);
      step();
      chk("R7 stall cleared", fill_stall, 0);

      // R6 malformed addresses
      do_fill(40'h00_0000_1080, 1'b0, "R6 refuse misaligned");
      chk("R6 error pulse", fill_err, 1);
      chk("R6 write index unchanged", ring_wr, 8);
      step();
      chk("R6 error one cycle", fill_err, 0);
      do_fill(40'h10_0000_0000, 1'b0, "R6 refuse wide");
      chk("R6 error pulse wide", fill_err, 1);
      chk("R6 write index unchanged wide", ring_wr, 8);
      look_slot = 8'd8;
      #1;
      chk("R6 nothing stored", look_desc, 0);

      // R5 descriptor readback from the scoreboard
      while (exp_slot_q.size() != 0) begin
         look_slot = exp_slot_q.pop_front();
         #1;
         chk("R5 stored descriptor", look_desc, exp_desc_q.pop_front());
      end
      look_slot = 8'd9;
      #1;
      chk("R5 untouched slot", look_desc, 0);
      step();
      chk("R8 final published", pub_wptr, 8);
      chk("R8 all publishes seen", exp_pub_q.size(), 0);
      chk("R8 publish count", pubs_seen, 2);

      // R4 full and empty
      set_pos(16'd8);
      chk("R4 full", {ring_full, ring_empty}, 2'b10);
      chk("R3 free space when equal", free_slots, 254);
      set_pos(16'd9);
      chk("R4 empty", {ring_full, ring_empty}, 2'b01);
      chk("R3 free space clamp", free_slots, 0);

      // R9 urgent threshold around half a ring
      set_pos(16'd200);
      chk("R9 urgent far ahead", urgent, 1);
      set_pos(16'd136);
      chk("R9 not urgent at half", urgent, 0);
      set_pos(16'd137);
      chk("R9 urgent just past half", urgent, 1);

      // R10 refill cadence
      set_pos(16'd200);
      for (int i = 0; i < 8; i++) begin
         consume = 1'b1; step(); consume = 1'b0; #1;
         chk("R10 refill on eighth", refill_req, (i == 7));
      end
      step();
      chk("R10 refill single pulse", refill_req, 0);
      for (int i = 0; i < 3; i++) begin
         consume = 1'b1; step(); consume = 1'b0; #1;
      end
      set_pos(16'd100);
      chk("R9 urgent dropped", urgent, 0);
      set_pos(16'd200);
      for (int i = 0; i < 8; i++) begin
         consume = 1'b1; step(); consume = 1'b0; #1;
         chk("R10 tally restarted", refill_req, (i == 7));
      end

      // R11 low watermark
      pool_cnt = 16'd6; step(); #1;
      chk("R11 above threshold", low_wm, 0);
      pool_cnt = 16'd5; step(); #1;
      chk("R11 at threshold", low_wm, 1);
      pool_cnt = 16'd0; step(); #1;
      chk("R11 below threshold", low_wm, 1);
      pool_cnt = 16'd200; step(); #1;
      chk("R11 recovered", low_wm, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule